// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns an arbitrary system clock into single-cycle enable pulses whose long-run average rate equals a chosen serial bit rate. A second pulse stream runs at a fixed multiple of that rate, for receivers that oversample the line. Other logic in the same clock domain uses these pulses as clock enables, so they never need a derived clock.

There is no integer divider. Each pulse stream has a phase accumulator that adds a constant every enabled cycle, and the carry out of its fractional part is the pulse. When the clock-to-rate ratio is not an integer, the spacing between pulses switches between the two nearest whole cycle counts. The long-run average stays at the ratio.

The increment is fixed when the design is elaborated, from the clock frequency, the bit rate and the accumulator width. It is rounded to the nearest integer. A synchronous reset clears both accumulators. An enable input freezes the phase without losing it.

Top module: `baud_tick_gen`

## Requirements
- R1: The increment is round((rate << W) / clkHz), evaluated as ((rate << (W-4)) + (clkHz >> 5)) / (clkHz >> 4). With the defaults (2 MHz, 115200 baud, W = 10) it is 59 for the bit tick and 472 for the 8x tick. Over 10240 enabled cycles after reset the bit tick therefore fires exactly 590 times and the oversampling tick 4720 times.
- R2: Let k be the number of enabled cycles since reset. After the k-th enabled edge, bitTick is high exactly when floor(k*59/1024) exceeds floor((k-1)*59/1024). The first bit tick comes after the 18th enabled edge.
- R3: With the enable held high, the distance between consecutive ticks, counted in enabled cycles, is always floor(2^W/INC) or ceil(2^W/INC). That is 17 or 18 for the bit tick and 2 or 3 for the oversampling tick.
- R4: ovsTick obeys the same law as R2, using increment 472 (eight times the bit rate). Its first pulse comes after the 3rd enabled edge.
- R5: rst is synchronous and active high, and takes priority over en. While it is applied both ticks are low. Counting of enabled cycles restarts from zero after it is released, so the next bit tick again needs 18 enabled edges.
- R6: With en low, the accumulators hold their phase and neither tick goes high in the cycle that follows a disabled edge. Tick timing continues counting only enabled cycles, as in R2.
- R7: With the default increments, a tick is high for exactly one clock and never on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high; clears both accumulators |
| en | input | 1 | Advance enable; when low the phase is held |
| bitTick | output | 1 | One-cycle pulse at the average bit rate |
| ovsTick | output | 1 | One-cycle pulse at the oversampling multiple of the bit rate (low when disabled by parameter) |

## Verification
A corrupted accumulator value shows at the ports as a shift in tick phase. The next bit tick comes earlier or later than the exact carry count predicts, and the mismatch appears within one tick period: at most 18 clocks for the bit stream and 3 for the oversampling stream. A wrong increment does not show up in any single short gap. It shows as a drift in the total tick count over thousands of cycles, which is why exact totals over a long window are compared. A broken hold path makes ticks appear after disabled cycles, or phase move while en is low, and the next resumed tick then lands off the predicted cycle.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

  // Strobes from the control module to each accumulator datapath.
  typedef struct packed {
    logic clear;  // synchronous clear of the phase
    logic step;   // add the increment this cycle
  } tickCtl_t;

  // Rounded phase increment, with the scaling arranged so that the
  // intermediate values stay inside 32-bit range for common clocks.
  function automatic longint unsigned calcInc(input longint unsigned clkHz,
                                              input longint unsigned rate,
                                              input int unsigned accW);
    longint unsigned num;
    longint unsigned den;
    num = (rate << (accW - 4)) + (clkHz >> 5);
    den = clkHz >> 4;
    return num / den;
  endfunction

endpackage

// File: rtl/baud_tick_ctrl.sv
module baud_tick_ctrl
  import baud_tick_pkg::*;
(
  input  logic     rstI,
  input  logic     enI,
  output tickCtl_t ctlO
);

  // Reset wins over enable; the accumulators see at most one strobe.
  always_comb begin
    ctlO.clear = rstI;
    ctlO.step  = enI & ~rstI;
  end

endmodule

// File: rtl/baud_tick_acc.sv
module baud_tick_acc
  import baud_tick_pkg::*;
#(
  parameter int unsigned ACC_W = 10,
  parameter int unsigned INC   = 59
) (
  input  logic     clk,
  input  tickCtl_t ctlI,
  output logic     tickO
);

  localparam logic [ACC_W:0] INC_V   = (ACC_W+1)'(INC);
  localparam int unsigned    SPAN    = 1 << ACC_W;
  localparam int unsigned    LO_GAP  = SPAN / INC;
  localparam int unsigned    HI_GAP  = (SPAN + INC - 1) / INC;
  localparam int unsigned    GAP_W   = $clog2(HI_GAP + 2) + 1;
  localparam logic [GAP_W-1:0] GAP_MAX = {GAP_W{1'b1}};

  // Fractional phase in the low ACC_W bits, carry in the top bit.
  logic [ACC_W:0] accQ;

  always_ff @(posedge clk) begin
    if (ctlI.clear) begin
      accQ <= '0;
    end else if (ctlI.step) begin
      accQ <= {1'b0, accQ[ACC_W-1:0]} + INC_V;
    end else begin
      accQ <= {1'b0, accQ[ACC_W-1:0]};
    end
  end

  assign tickO = accQ[ACC_W];

  // Count of steps since the last tick, used by the spacing check.
  logic [GAP_W-1:0] gapQ;

  always_ff @(posedge clk) begin
    if (ctlI.clear) begin
      gapQ <= '0;
    end else if (tickO) begin
      gapQ <= GAP_W'(ctlI.step);
    end else if (ctlI.step && gapQ != GAP_MAX) begin
      gapQ <= gapQ + 1'b1;
    end
  end

  // A pulse only follows an enabled step (R6).
  p_tick_after_step_r6: assert property (@(posedge clk) disable iff (ctlI.clear)
    tickO |-> $past(ctlI.step))
    else $error("tick without a preceding step");

  // Phase holds while idle (R6).
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (ctlI.clear)
    !ctlI.step |=> $stable(accQ[ACC_W-1:0]))
    else $error("phase moved while idle");

  // Phase is zero and quiet right after reset release (R5).
  p_clear_zero_r5: assert property (@(posedge clk) disable iff (ctlI.clear)
    $fell(ctlI.clear) |-> (accQ == '0))
    else $error("accumulator not cleared by reset");

  // Tick spacing stays between the two neighbouring integers (R3).
  p_gap_range_r3: assert property (@(posedge clk) disable iff (ctlI.clear)
    tickO |-> (gapQ >= GAP_W'(LO_GAP) && gapQ <= GAP_W'(HI_GAP)))
    else $error("tick spacing out of range");

  generate
    if (2 * INC <= SPAN) begin : g_single
      // With at most half-range increments a tick never repeats (R7).
      p_tick_single_r7: assert property (@(posedge clk) disable iff (ctlI.clear)
        tickO |=> !tickO)
        else $error("tick wider than one clock");
    end
  endgenerate

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 2_000_000,
  parameter int unsigned BAUD       = 115_200,
  parameter int unsigned ACC_W      = 10,
  parameter int unsigned OVS_FACTOR = 8,
  parameter bit          OVS_EN     = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic bitTick,
  output logic ovsTick
);

  localparam longint unsigned SPAN    = 64'd1 << ACC_W;
  localparam longint unsigned BIT_INC = calcInc(CLK_HZ, BAUD, ACC_W);
  localparam longint unsigned OVS_INC = calcInc(CLK_HZ, longint'(BAUD) * OVS_FACTOR, ACC_W);

  // Elaboration-time sanity of the derived increments.
  initial begin
    p_param_width: assert (ACC_W >= 5 && ACC_W <= 30)
      else $error("accumulator width out of range");
    p_param_bit_inc: assert (BIT_INC != 0 && BIT_INC < SPAN)
      else $error("bit increment is zero or reaches 2^W");
    p_param_ovs_inc: assert (!OVS_EN || (OVS_INC != 0 && OVS_INC < SPAN))
      else $error("oversampling increment is zero or reaches 2^W");
  end

  tickCtl_t ctl;

  baud_tick_ctrl u_ctrl (
    .rstI (rst),
    .enI  (en),
    .ctlO (ctl)
  );

  baud_tick_acc #(
    .ACC_W (ACC_W),
    .INC   (int'(BIT_INC))
  ) u_bitAcc (
    .clk   (clk),
    .ctlI  (ctl),
    .tickO (bitTick)
  );

  generate
    if (OVS_EN) begin : g_ovs
      baud_tick_acc #(
        .ACC_W (ACC_W),
        .INC   (int'(OVS_INC))
      ) u_ovsAcc (
        .clk   (clk),
        .ctlI  (ctl),
        .tickO (ovsTick)
      );
    end else begin : g_noOvs
      assign ovsTick = 1'b0;
    end
  endgenerate

endmodule

// File: tb/tb_baud_tick_gen.sv
`timescale 1ns/1ps
module tb_baud_tick_gen;

  localparam longint INC_BIT = 59;
  localparam longint INC_OVS = 472;
  localparam longint SPAN    = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic bitTick, ovsTick;

  always #2 clk = ~clk;  // 250 MHz

  baud_tick_gen dut (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .bitTick (bitTick),
    .ovsTick (ovsTick)
  );

  int nTests = 0;
  int nFail  = 0;
  bit finished = 1'b0;

  // Bench model state
  longint kSteps = 0;
  int mmBit, mmOvs, nBit, nOvs, dblBit;
  int gapB, gapO, minGB, maxGB, minGO, maxGO;
  logic prevBit = 1'b0;

  function automatic bit carry(input longint k, input longint inc);
    return (k > 0) && (((k * inc) / SPAN) != (((k - 1) * inc) / SPAN));
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clearStats();
    mmBit = 0; mmOvs = 0; nBit = 0; nOvs = 0; dblBit = 0;
    minGB = 999; maxGB = 0; minGO = 999; maxGO = 0;
  endtask

  task automatic cyc(input logic e, input logic r);
    bit expB, expO;
    en = e; rst = r;
    @(posedge clk); #1;
    if (r) begin
      kSteps = 0; gapB = 0; gapO = 0;
    end else if (e) begin
      kSteps++; gapB++; gapO++;
    end
    expB = (!r && e) ? carry(kSteps, INC_BIT) : 1'b0;
    expO = (!r && e) ? carry(kSteps, INC_OVS) : 1'b0;
    if (bitTick !== expB) mmBit++;
    if (ovsTick !== expO) mmOvs++;
    if (bitTick === 1'b1) begin
      nBit++;
      if (prevBit) dblBit++;
      if (gapB < minGB) minGB = gapB;
      if (gapB > maxGB) maxGB = gapB;
      gapB = 0;
    end
    if (ovsTick === 1'b1) begin
      nOvs++;
      if (gapO < minGO) minGO = gapO;
      if (gapO > maxGO) maxGO = gapO;
      gapO = 0;
    end
    prevBit = (bitTick === 1'b1);
  endtask

  task automatic testReset();
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1);
    check("R5", "bitTick during reset", bitTick, 0);
    check("R5", "ovsTick during reset", ovsTick, 0);
  endtask

  task automatic testFirstTick();
    int firstB, firstO;
    firstB = 0; firstO = 0;
    cyc(1'b1, 1'b1);
    clearStats();
    for (int i = 1; i <= 20; i++) begin
      cyc(1'b1, 1'b0);
      if (bitTick && firstB == 0) firstB = i;
      if (ovsTick && firstO == 0) firstO = i;
    end
    check("R2", "first bit tick edge", firstB, 18);
    check("R4", "first ovs tick edge", firstO, 3);
  endtask

  task automatic testSteady();
    clearStats();
    for (int i = 0; i < 2000; i++) cyc(1'b1, 1'b0);
    check("R2", "bit tick mismatches", mmBit, 0);
    check("R4", "ovs tick mismatches", mmOvs, 0);
    check("R3", "min bit gap", minGB, 17);
    check("R3", "max bit gap", maxGB, 18);
    check("R3", "min ovs gap", minGO, 2);
    check("R3", "max ovs gap", maxGO, 3);
    check("R7", "back-to-back bit ticks", dblBit, 0);
  endtask

  task automatic testRate();
    cyc(1'b1, 1'b1);
    clearStats();
    for (int i = 0; i < 10240; i++) cyc(1'b1, 1'b0);
    check("R1", "bit ticks in 10240 cycles", nBit, 590);
    check("R1", "ovs ticks in 10240 cycles", nOvs, 4720);
  endtask

  task automatic testGating();
    cyc(1'b0, 1'b1);
    clearStats();
    for (int i = 0; i < 600; i++) cyc((i % 3) == 0, 1'b0);
    check("R6", "bit mismatches, sparse enable", mmBit, 0);
    check("R6", "ovs mismatches, sparse enable", mmOvs, 0);
    check("R6", "bit ticks vs enabled steps", nBit, (kSteps * INC_BIT) / SPAN);
    clearStats();
    for (int i = 0; i < 50; i++) cyc(1'b0, 1'b0);
    check("R6", "bit ticks while idle", nBit, 0);
    check("R6", "ovs ticks while idle", nOvs, 0);
    clearStats();
    for (int i = 0; i < 100; i++) cyc(1'b1, 1'b0);
    check("R6", "bit mismatches after resume", mmBit, 0);
    check("R6", "ovs mismatches after resume", mmOvs, 0);
  endtask

  task automatic testMidReset();
    int firstB;
    firstB = 0;
    for (int i = 0; i < 25; i++) cyc(1'b1, 1'b0);
    cyc(1'b1, 1'b1);
    check("R5", "bitTick in mid-run reset cycle", bitTick, 0);
    check("R5", "ovsTick in mid-run reset cycle", ovsTick, 0);
    for (int i = 1; i <= 20; i++) begin
      cyc(1'b1, 1'b0);
      if (bitTick && firstB == 0) firstB = i;
    end
    check("R5", "first bit tick after mid-run reset", firstB, 18);
  endtask

  initial begin
    testReset();
    testFirstTick();
    testSteady();
    testRate();
    testGating();
    testMidReset();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule